// File: doc/BRIEF.md
# Host-Sliced Dual-Port Memory Core

This block is a parameterised dual-port RAM shared between a host and user logic. User logic sees an ordinary synchronous RAM port: an entry index, write data, a write enable and read data, always whole entries of the configured width. The host reaches the same storage through a narrow 16-bit register bus. Each wide entry appears to the host as a run of consecutive 16-bit slices, so a host transaction reads or writes a single slice.

A mode parameter chooses which side may write. In bidirectional mode both sides read and write. In host-to-logic mode the host writes and the user port only reads. In logic-to-host mode the user port writes and the host only reads. The disabled paths are removed at elaboration, so each one-way mode maps onto a simple dual-port array. A host update that spans several slices is not atomic: between host transactions the user port can see an entry whose slices are partly new and partly old.

Top module: `hsm_core`

## Requirements
- R1: An entry uses NSL = ceil(WIDTH/16) slices. The host address of slice s of entry e is BASE + e*NSL + s. Slice s maps to entry bits 16*s+15 down to 16*s, so slice 0 holds bits 15:0.
- R2: A host write to one slice changes only the bits of that slice. The other slices of the entry keep their contents.
- R3: An accepted host read (host_rd high with an in-range address in a mode that allows host reads) raises host_rvalid for exactly one cycle, on the clock edge after the request, with the slice on host_rdata. host_rdata is zero whenever host_rvalid is low.
- R4: Bits of the last slice above WIDTH read as zero. Host write data for those bit positions is discarded.
- R5: A user write stores all WIDTH bits of user_wdata at user_addr. user_rdata shows the entry at user_addr one clock after the address is presented. A read and a write to the same entry in the same cycle return the contents from before the write.
- R6: Host accesses with an address below BASE or at or above BASE + DEPTH*NSL are ignored: no entry changes and host_rvalid stays low.
- R7: In bidirectional mode, when the host and the user port write the same entry in the same cycle, the user write wins on every slice.
- R8: In host-to-logic mode (MODE_HOST_WR), user_we has no effect on the contents, and host reads never raise host_rvalid.
- R9: In logic-to-host mode (MODE_USER_WR), host writes have no effect on the contents, and user_rdata stays zero.
- R10: While rst_n is low, host_rvalid, host_rdata and user_rdata are zero.
- R11: A host slice write becomes visible on the user port. A user read issued in the cycle after the write returns the new slice together with the unchanged slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 16 | Host bus address (slice address) |
| host_wdata | input | 16 | Host write data for one slice |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read slice, zero when not valid |
| host_rvalid | output | 1 | Host read data valid, one cycle per accepted read |
| user_addr | input | AW | User entry index |
| user_wdata | input | WIDTH | User write data |
| user_we | input | 1 | User write enable |
| user_rdata | output | WIDTH | User read data, one clock latency |

## Verification
A wrong slice index or entry index in the host decode shows up on the first host read that follows a user write of a known pattern. The wrong 16-bit field comes back one cycle after the request. A missing per-slice mask or a wrong last-slice mask shows up on the user port on the cycle after a single host slice write, as a change in neighbouring slices or in bits above WIDTH. A valid flag that sticks or is dropped shows within one cycle of a read. A mode gate left open shows as a changed entry the next time the other port reads it.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

   localparam int SLICE_W = 16;

   typedef enum logic [1:0] {
      MODE_BIDIR   = 2'd0,
      MODE_HOST_WR = 2'd1,
      MODE_USER_WR = 2'd2
   } hsm_mode_e;

   function automatic int slices_for(input int width);
      return (width + SLICE_W - 1) / SLICE_W;
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hsm_addr_map.sv
module hsm_addr_map #(
   parameter int NSL   = 3,
   parameter int DEPTH = 16,
   parameter int BASE  = 0,
   parameter int IW    = 4,
   parameter int SLW   = 2
) (
   input  logic [15:0]    addr,
   output logic           in_range,
   output logic [IW-1:0]  entry,
   output logic [SLW-1:0] slice
);
   localparam int TOTAL = DEPTH * NSL;

   logic [16:0] off;

   assign off      = {1'b0, addr} - 17'(BASE);
   assign in_range = ({1'b0, addr} >= 17'(BASE)) && (off < 17'(TOTAL));

   generate
      if ((NSL & (NSL - 1)) == 0) begin : g_pow2
         if (NSL == 1) begin : g_one
            assign slice = '0;
            assign entry = IW'(off);
         end else begin : g_many
            localparam int SH = $clog2(NSL);
            assign slice = off[SLW-1:0];
            assign entry = IW'(off >> SH);
         end
      end else begin : g_div
         assign slice = SLW'(off % 17'(NSL));
         assign entry = IW'(off / 17'(NSL));
      end
   endgenerate

endmodule

// File: rtl/hsm_store.sv
module hsm_store #(
   parameter int NSL     = 3,
   parameter int DEPTH   = 16,
   parameter int IW      = 4,
   parameter bit HOST_WR = 1'b1,
   parameter bit USER_WR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IW-1:0]       a_idx,
   input  logic [NSL-1:0]      a_slice_we,
   input  logic [15:0]         a_wdata,
   output logic [NSL*16-1:0]   a_word,
   input  logic [IW-1:0]       b_idx,
   input  logic                b_we,
   input  logic [NSL*16-1:0]   b_wdata,
   output logic [NSL*16-1:0]   b_word
);
   logic [NSL-1:0][15:0] mem [DEPTH];

   logic [NSL-1:0] a_we_eff;
   logic           b_we_eff;
   logic           a_ok;
   logic           b_ok;

   assign a_ok = 32'(a_idx) < DEPTH;
   assign b_ok = 32'(b_idx) < DEPTH;

   generate
      if (HOST_WR) begin : g_a_wr
         assign a_we_eff = a_slice_we;
      end else begin : g_a_ro
         assign a_we_eff = '0;
      end
      if (USER_WR) begin : g_b_wr
         assign b_we_eff = b_we;
      end else begin : g_b_ro
         assign b_we_eff = 1'b0;
      end
   endgenerate

   // The user write is placed last so it takes precedence on a shared entry.
   always_ff @(posedge clk) begin
      for (int s = 0; s < NSL; s++) begin
         if (a_we_eff[s] && a_ok) mem[a_idx][s] <= a_wdata;
      end
      if (b_we_eff && b_ok) mem[b_idx] <= b_wdata;
   end

   // Registered reads return the contents from before any write at the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_word <= '0;
         b_word <= '0;
      end else begin
         a_word <= a_ok ? mem[a_idx] : '0;
         b_word <= b_ok ? mem[b_idx] : '0;
      end
   end

endmodule

// File: rtl/hsm_slice_mux.sv
module hsm_slice_mux #(
   parameter int NSL = 3,
   parameter int SLW = 2
) (
   input  logic [NSL*16-1:0] word,
   input  logic [SLW-1:0]    sel,
   input  logic              valid,
   output logic [15:0]       slice_out
);
   logic [NSL-1:0][15:0] parts;

   assign parts = word;

   always_comb begin
      slice_out = '0;
      if (valid && (32'(sel) < NSL)) slice_out = parts[sel];
   end

endmodule

// File: rtl/hsm_core.sv
module hsm_core #(
   parameter int                WIDTH = 40,
   parameter int                DEPTH = 16,
   parameter hsm_pkg::hsm_mode_e MODE = hsm_pkg::MODE_BIDIR,
   parameter int                BASE  = 256,
   localparam int               AW    = hsm_pkg::idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      host_addr,
   input  logic [15:0]      host_wdata,
   input  logic             host_wr,
   input  logic             host_rd,
   output logic [15:0]      host_rdata,
   output logic             host_rvalid,
   input  logic [AW-1:0]    user_addr,
   input  logic [WIDTH-1:0] user_wdata,
   input  logic             user_we,
   output logic [WIDTH-1:0] user_rdata
);
   localparam int          NSL        = hsm_pkg::slices_for(WIDTH);
   localparam int          SLW        = hsm_pkg::idx_bits(NSL);
   localparam int          WW         = NSL * 16;
   localparam int          LAST_BITS  = WIDTH - (NSL - 1) * 16;
   localparam logic [15:0] LAST_MASK  = 16'((32'h1 << LAST_BITS) - 1);
   localparam bit          HOST_WR_OK = (MODE != hsm_pkg::MODE_USER_WR);
   localparam bit          USER_WR_OK = (MODE != hsm_pkg::MODE_HOST_WR);
   localparam bit          HOST_RD_OK = (MODE != hsm_pkg::MODE_HOST_WR);
   localparam bit          USER_RD_OK = (MODE != hsm_pkg::MODE_USER_WR);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("hsm_core: WIDTH must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("hsm_core: DEPTH must be at least 1");
      end
      if (BASE < 0 || BASE + DEPTH * NSL > 65536) begin : g_bad_range
         $error("hsm_core: slice address range does not fit the 16-bit host bus");
      end
   endgenerate

   logic            h_in_range;
   logic [AW-1:0]   h_entry;
   logic [SLW-1:0]  h_slice;
   logic [NSL-1:0]  h_slice_we;
   logic [15:0]     h_wdata_m;
   logic            h_rd_fire;
   logic            rvalid_q;
   logic [SLW-1:0]  slice_q;
   logic [WW-1:0]   a_word;
   logic [WW-1:0]   b_word;

   hsm_addr_map #(
      .NSL  (NSL),
      .DEPTH(DEPTH),
      .BASE (BASE),
      .IW   (AW),
      .SLW  (SLW)
   ) u_map (
      .addr    (host_addr),
      .in_range(h_in_range),
      .entry   (h_entry),
      .slice   (h_slice)
   );

   // Mask off write bits beyond WIDTH when the last slice is addressed.
   assign h_wdata_m = (32'(h_slice) == NSL - 1) ? (host_wdata & LAST_MASK) : host_wdata;

   generate
      for (genvar s = 0; s < NSL; s++) begin : g_slice_we
         assign h_slice_we[s] = HOST_WR_OK && host_wr && h_in_range && (32'(h_slice) == s);
      end
   endgenerate

   assign h_rd_fire = HOST_RD_OK && host_rd && h_in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         slice_q  <= '0;
      end else begin
         rvalid_q <= h_rd_fire;
         if (h_rd_fire) slice_q <= h_slice;
      end
   end

   hsm_store #(
      .NSL    (NSL),
      .DEPTH  (DEPTH),
      .IW     (AW),
      .HOST_WR(HOST_WR_OK),
      .USER_WR(USER_WR_OK)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_idx     (h_entry),
      .a_slice_we(h_slice_we),
      .a_wdata   (h_wdata_m),
      .a_word    (a_word),
      .b_idx     (user_addr),
      .b_we      (user_we),
      .b_wdata   (WW'(user_wdata)),
      .b_word    (b_word)
   );

   hsm_slice_mux #(
      .NSL(NSL),
      .SLW(SLW)
   ) u_mux (
      .word     (a_word),
      .sel      (slice_q),
      .valid    (rvalid_q),
      .slice_out(host_rdata)
   );

   assign host_rvalid = rvalid_q;

   generate
      if (USER_RD_OK) begin : g_user_rd
         assign user_rdata = b_word[WIDTH-1:0];
      end else begin : g_user_nord
         assign user_rdata = '0;
      end
   endgenerate

endmodule

// File: rtl/hsm_core_chk.sv
module hsm_core_chk #(
   parameter int                WIDTH = 40,
   parameter int                DEPTH = 16,
   parameter hsm_pkg::hsm_mode_e MODE = hsm_pkg::MODE_BIDIR,
   parameter int                BASE  = 256,
   localparam int               AW    = hsm_pkg::idx_bits(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      host_addr,
   input logic             host_wr,
   input logic             host_rd,
   input logic [15:0]      host_rdata,
   input logic             host_rvalid,
   input logic [WIDTH-1:0] user_rdata
);
   localparam int          NSL   = hsm_pkg::slices_for(WIDTH);
   localparam int          TOTAL = DEPTH * NSL;
   localparam int          LBITS = WIDTH - (NSL - 1) * 16;
   localparam logic [15:0] HIGH  = ~16'((32'h1 << LBITS) - 1);
   localparam bit          RD_OK = (MODE != hsm_pkg::MODE_HOST_WR);

   logic in_rng;
   logic last_sel;

   assign in_rng = (int'(host_addr) >= BASE) && (int'(host_addr) < BASE + TOTAL);
   assign last_sel = in_rng && (((int'(host_addr) - BASE) % NSL) == NSL - 1);

   assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && in_rng && RD_OK) |=> host_rvalid);

   assert_rvalid_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_rd));

   assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rvalid |-> (host_rdata == 16'h0));

   assert_outside_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !in_rng) |=> !host_rvalid);

   assert_last_slice_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rvalid && $past(last_sel)) |-> ((host_rdata & HIGH) == 16'h0));

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (!host_rvalid && host_rdata == 16'h0 && user_rdata == '0));

   generate
      if (MODE == hsm_pkg::MODE_HOST_WR) begin : g_h2l
         assert_no_host_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !host_rvalid);
      end
      if (MODE == hsm_pkg::MODE_USER_WR) begin : g_l2h
         assert_user_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            user_rdata == '0);
      end
   endgenerate

endmodule

bind hsm_core hsm_core_chk #(
   .WIDTH(WIDTH),
   .DEPTH(DEPTH),
   .MODE (MODE),
   .BASE (BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_rdata (host_rdata),
   .host_rvalid(host_rvalid),
   .user_rdata (user_rdata)
);

// File: tb/sim_hsm_core.sv
`timescale 1ns/1ps
module sim_hsm_core;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // u0: bidirectional, 40-bit entries (3 slices), 16 entries, base 0x100
   logic [15:0] h0_addr = '0, h0_wd = '0, h0_rdata;
   logic        h0_wr = 1'b0, h0_rd = 1'b0, h0_rv;
   logic [3:0]  u0_addr = '0;
   logic [39:0] u0_wd = '0, u0_rd;
   logic        u0_we = 1'b0;

   // u1: host-to-logic, 16-bit entries (1 slice), 8 entries, base 0x20
   logic [15:0] h1_addr = '0, h1_wd = '0, h1_rdata;
   logic        h1_wr = 1'b0, h1_rd = 1'b0, h1_rv;
   logic [2:0]  u1_addr = '0;
   logic [15:0] u1_wd = '0, u1_rd;
   logic        u1_we = 1'b0;

   // u2: logic-to-host, 33-bit entries (3 slices), 4 entries, base 0
   logic [15:0] h2_addr = '0, h2_wd = '0, h2_rdata;
   logic        h2_wr = 1'b0, h2_rd = 1'b0, h2_rv;
   logic [1:0]  u2_addr = '0;
   logic [32:0] u2_wd = '0, u2_rd;
   logic        u2_we = 1'b0;

   hsm_core #(.WIDTH(40), .DEPTH(16), .MODE(hsm_pkg::MODE_BIDIR), .BASE(256)) u0 (
      .clk(clk), .rst_n(rst_n),
      .host_addr(h0_addr), .host_wdata(h0_wd), .host_wr(h0_wr), .host_rd(h0_rd),
      .host_rdata(h0_rdata), .host_rvalid(h0_rv),
      .user_addr(u0_addr), .user_wdata(u0_wd), .user_we(u0_we), .user_rdata(u0_rd));

   hsm_core #(.WIDTH(16), .DEPTH(8), .MODE(hsm_pkg::MODE_HOST_WR), .BASE(32)) u1 (
      .clk(clk), .rst_n(rst_n),
      .host_addr(h1_addr), .host_wdata(h1_wd), .host_wr(h1_wr), .host_rd(h1_rd),
      .host_rdata(h1_rdata), .host_rvalid(h1_rv),
      .user_addr(u1_addr), .user_wdata(u1_wd), .user_we(u1_we), .user_rdata(u1_rd));

   hsm_core #(.WIDTH(33), .DEPTH(4), .MODE(hsm_pkg::MODE_USER_WR), .BASE(0)) u2 (
      .clk(clk), .rst_n(rst_n),
      .host_addr(h2_addr), .host_wdata(h2_wd), .host_wr(h2_wr), .host_rd(h2_rd),
      .host_rdata(h2_rdata), .host_rvalid(h2_rv),
      .user_addr(u2_addr), .user_wdata(u2_wd), .user_we(u2_we), .user_rdata(u2_rd));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---- per-instance access helpers (inputs change just after a falling edge)
   task automatic h0_write(input logic [15:0] a, input logic [15:0] d);
      h0_addr = a; h0_wd = d; h0_wr = 1'b1;
      @(negedge clk); h0_wr = 1'b0;
   endtask
   task automatic h0_read(input logic [15:0] a, output logic v, output logic [15:0] d);
      h0_addr = a; h0_rd = 1'b1;
      @(negedge clk); v = h0_rv; d = h0_rdata; h0_rd = 1'b0;
   endtask
   task automatic u0_write(input logic [3:0] a, input logic [39:0] d);
      u0_addr = a; u0_wd = d; u0_we = 1'b1;
      @(negedge clk); u0_we = 1'b0;
   endtask
   task automatic u0_read(input logic [3:0] a, output logic [39:0] d);
      u0_addr = a; u0_we = 1'b0;
      @(negedge clk); d = u0_rd;
   endtask

   // ---- scenarios
   task automatic t_reset();
      chk("R10 host_rvalid in reset", 64'(h0_rv), 64'h0);
      chk("R10 host_rdata in reset", 64'(h0_rdata), 64'h0);
      chk("R10 user_rdata in reset", 64'(u0_rd), 64'h0);
   endtask

   task automatic t_slice_map();
      logic v; logic [15:0] d;
      u0_write(4'd5, 40'hA1_B2C3_D4E5);
      h0_read(16'h010F, v, d);
      chk("R3 rvalid one cycle after read", 64'(v), 64'h1);
      chk("R1 slice 0 holds bits 15:0", 64'(d), 64'hD4E5);
      @(negedge clk);
      chk("R3 rvalid drops after one cycle", 64'(h0_rv), 64'h0);
      chk("R3 rdata zero when not valid", 64'(h0_rdata), 64'h0);
      h0_read(16'h0110, v, d);
      chk("R1 slice 1 holds bits 31:16", 64'(d), 64'hB2C3);
      h0_read(16'h0111, v, d);
      chk("R1 slice 2 holds bits 39:32", 64'(d), 64'h00A1);
   endtask

   task automatic t_slice_write();
      logic [39:0] w;
      h0_write(16'h0110, 16'h1234);
      u0_read(4'd5, w);
      chk("R2 R11 only slice 1 changes, seen by user", 64'(w), 64'hA1_1234_D4E5);
   endtask

   task automatic t_upper_bits();
      logic v; logic [15:0] d; logic [39:0] w;
      h0_write(16'h0111, 16'hFFFF);
      h0_read(16'h0111, v, d);
      chk("R4 last slice upper bits read zero", 64'(d), 64'h00FF);
      u0_read(4'd5, w);
      chk("R4 user sees only bits within width", 64'(w), 64'hFF_1234_D4E5);
   endtask

   task automatic t_out_of_range();
      logic v; logic [15:0] d; logic [39:0] w;
      u0_write(4'd0, 40'h11_2222_3333);
      u0_write(4'd15, 40'h44_5555_6666);
      h0_write(16'h00FF, 16'hDEAD);
      h0_write(16'h0130, 16'hBEEF);
      h0_read(16'h0130, v, d);
      chk("R6 read above range gives no rvalid", 64'(v), 64'h0);
      h0_read(16'h00FF, v, d);
      chk("R6 read below range gives no rvalid", 64'(v), 64'h0);
      u0_read(4'd0, w);
      chk("R6 entry 0 unchanged", 64'(w), 64'h11_2222_3333);
      u0_read(4'd15, w);
      chk("R6 entry 15 unchanged", 64'(w), 64'h44_5555_6666);
   endtask

   task automatic t_user_port();
      logic [39:0] w;
      u0_write(4'd3, 40'h01_0203_0405);
      u0_addr = 4'd3; u0_wd = 40'hF0_E0D0_C0B0; u0_we = 1'b1;
      @(negedge clk); w = u0_rd; u0_we = 1'b0;
      chk("R5 read during write returns old entry", 64'(w), 64'h01_0203_0405);
      u0_read(4'd3, w);
      chk("R5 full-width user write stored", 64'(w), 64'hF0_E0D0_C0B0);
   endtask

   task automatic t_collision();
      logic [39:0] w;
      h0_addr = 16'h0100 + 16'd21; h0_wd = 16'hAAAA; h0_wr = 1'b1;
      u0_addr = 4'd7; u0_wd = 40'h55_6677_8899; u0_we = 1'b1;
      @(negedge clk); h0_wr = 1'b0; u0_we = 1'b0;
      u0_read(4'd7, w);
      chk("R7 user write wins on shared entry", 64'(w), 64'h55_6677_8899);
   endtask

   task automatic t_host_to_logic();
      h1_addr = 16'h0023; h1_wd = 16'hBEEF; h1_wr = 1'b1;
      @(negedge clk); h1_wr = 1'b0;
      u1_addr = 3'd3;
      @(negedge clk);
      chk("R1 single-slice entry written by host", 64'(u1_rd), 64'hBEEF);
      u1_wd = 16'h1111; u1_we = 1'b1;
      @(negedge clk); u1_we = 1'b0;
      @(negedge clk);
      chk("R8 user write has no effect", 64'(u1_rd), 64'hBEEF);
      h1_addr = 16'h0023; h1_rd = 1'b1;
      @(negedge clk); h1_rd = 1'b0;
      chk("R8 host read gives no rvalid", 64'(h1_rv), 64'h0);
   endtask

   task automatic t_logic_to_host();
      u2_addr = 2'd2; u2_wd = 33'h1_8765_4321; u2_we = 1'b1;
      @(negedge clk); u2_we = 1'b0;
      chk("R9 user_rdata stays zero", 64'(u2_rd), 64'h0);
      h2_addr = 16'd6; h2_wd = 16'h5555; h2_wr = 1'b1;
      @(negedge clk); h2_wr = 1'b0;
      h2_addr = 16'd6; h2_rd = 1'b1;
      @(negedge clk); h2_rd = 1'b0;
      chk("R9 host write ignored, rvalid", 64'(h2_rv), 64'h1);
      chk("R9 host write ignored, slice 0", 64'(h2_rdata), 64'h4321);
      h2_addr = 16'd8; h2_rd = 1'b1;
      @(negedge clk); h2_rd = 1'b0;
      chk("R4 single-bit last slice", 64'(h2_rdata), 64'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_slice_map();
      t_slice_write();
      t_upper_bits();
      t_out_of_range();
      t_user_port();
      t_collision();
      t_host_to_logic();
      t_logic_to_host();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule